// File: doc/BRIEF.md
# Serial Flash Write-Protection Controller

This block holds the protection state of a serial NOR flash and decides, one command at a time, whether a command may proceed. It keeps a status-register lock bit, a three-bit block-protect level and the write enable latch. It samples an active-low write-protect pin. Decoded commands arrive with an address and a data byte. These are write enable, write disable, status write, page program, sector erase and chip erase. One cycle later the block answers with accept or reject and the resulting status byte.

The lock bit and the pin together form a hardware lock on the status byte. The lock can be entered in either order. Only a high level on the pin releases it. The block-protect level fences a top-down region of the sector array against program and erase. The serial shifter, the opcode decoder, the array itself and its timing sit outside this block.

Top module: `flash_wp_ctrl`

## Requirements
- R1: After reset the status byte reads 0x00, the hardware-lock output is 0 and no response is valid.
- R2: Opcode 1 (write enable) is always accepted and sets the latch, status bit 1. Opcode 2 (write disable) is always accepted and clears it. No other command sets the latch.
- R3: A status write (opcode 3) that arrives while the latch is clear is rejected and changes nothing.
- R4: While the lock bit is 0, a status write with the latch set is accepted at either pin level. It loads data bits 7 and 4:2 into the lock bit and the protect level, and the pin level has no effect.
- R5: While the lock bit is 1 and the synchronized pin is high, a status write with the latch set is accepted.
- R6: While the lock bit is 1 and the synchronized pin is low, the hardware-lock output is 1. Every status write is rejected and the lock bit and protect level keep their values. The lock is reached by setting the lock bit with the pin low, or by lowering the pin after the lock bit is set.
- R7: Only a high pin clears the hardware lock; commands do not. The pin passes through two synchronizer flops, and the lock output is registered, so the output follows a pin change on the third rising edge.
- R8: Page program (opcode 4) and sector erase (opcode 5) decode the sector from the address bits above the sector offset. They are rejected inside the protected region and accepted outside it when the latch is set. Level 0 protects nothing, and level 7 protects every sector. A level n from 1 to 6 protects the top 2^(n-1) sectors.
- R9: Chip erase (opcode 6) is accepted only with the latch set and a protect level of 0.
- R10: Every accepted status write, program or erase clears the latch. A rejected command leaves the latch unchanged.
- R11: The status byte carries the lock bit in bit 7, the protect level in bits 4:2 and the latch in bit 1, with all other bits 0. A response is valid exactly one cycle after a command and shows the status after that command.
- R12: Opcodes 0 and 7 are rejected and change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wp_n_i | input | 1 | Write-protect pin, active low, asynchronous |
| cmd_valid_i | input | 1 | Command strobe, one cycle per command |
| cmd_op_i | input | 3 | Decoded command code |
| cmd_addr_i | input | SECTOR_W+OFFSET_W | Byte address for program and sector erase |
| cmd_data_i | input | 8 | Data byte for status write |
| rsp_valid_o | output | 1 | Response strobe |
| rsp_accept_o | output | 1 | 1 when the command was accepted |
| rsp_status_o | output | 8 | Status byte after the command |
| hpm_o | output | 1 | Hardware lock active |

## Verification
The bench builds the block with its defaults: 128 sectors of 64 KiB and a two-stage synchronizer. At this size every protect level from one sector up to the whole array is reachable. The bench probes the first protected and the last unprotected sector at levels 1, 3 and 6, and any sector at level 7. Both orders of entering the hardware lock are driven. Enough cycles are allowed for the pin to cross the synchronizer and reach the registered lock output.

// File: rtl/wp_pkg.sv
package wp_pkg;
  typedef enum logic [2:0] {
    CMD_NOP        = 3'd0,
    CMD_WR_EN      = 3'd1,
    CMD_WR_DIS     = 3'd2,
    CMD_SR_WRITE   = 3'd3,
    CMD_PAGE_PROG  = 3'd4,
    CMD_SECT_ERASE = 3'd5,
    CMD_CHIP_ERASE = 3'd6,
    CMD_RSVD       = 3'd7
  } wp_cmd_e;

  localparam int unsigned LVL_W      = 3;
  localparam int unsigned SR_LOCK    = 7;
  localparam int unsigned SR_LVL_LO  = 2;
  localparam int unsigned SR_LATCH   = 1;
  localparam logic [LVL_W-1:0] LVL_ALL = '1;
endpackage

// File: rtl/wp_sync.sv
module wp_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '1;   // pin released = unprotected
    else         chain_q <= {chain_q[STAGES-2:0], async_i};
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/wp_region.sv
module wp_region
  import wp_pkg::*;
#(
  parameter int unsigned SECTOR_W = 7
) (
  input  logic [LVL_W-1:0]    lvl_i,
  input  logic [SECTOR_W-1:0] sector_i,
  output logic                prot_o
);
  logic [SECTOR_W-1:0] low_mask;

  // level n (1..6) covers the top 2^(n-1) sectors: upper bits all ones
  always_comb begin
    low_mask = '0;
    for (int i = 0; i < SECTOR_W; i++)
      if (i < int'(lvl_i) - 1) low_mask[i] = 1'b1;
    if (lvl_i == '0)          prot_o = 1'b0;
    else if (lvl_i == LVL_ALL) prot_o = 1'b1;
    else                      prot_o = &(sector_i | low_mask);
  end
endmodule

// File: rtl/wp_core.sv
module wp_core
  import wp_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  input  wp_cmd_e          cmd_op_i,
  input  logic [7:0]       cmd_data_i,
  input  logic             sect_prot_i,
  input  logic             pin_high_i,
  output logic             accept_o,
  output logic             lock_o,
  output logic [LVL_W-1:0] lvl_o,
  output logic             latch_o
);
  logic             lock_q, latch_q;
  logic [LVL_W-1:0] lvl_q;
  logic             hw_locked;
  logic             unused_data;

  assign unused_data = ^{cmd_data_i[6:5], cmd_data_i[1:0]};
  assign hw_locked   = lock_q & ~pin_high_i;

  always_comb begin
    unique case (cmd_op_i)
      CMD_WR_EN, CMD_WR_DIS:         accept_o = 1'b1;
      CMD_SR_WRITE:                  accept_o = latch_q & ~hw_locked;
      CMD_PAGE_PROG, CMD_SECT_ERASE: accept_o = latch_q & ~sect_prot_i;
      CMD_CHIP_ERASE:                accept_o = latch_q & (lvl_q == '0);
      default:                       accept_o = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q  <= 1'b0;
      lvl_q   <= '0;
      latch_q <= 1'b0;
    end else if (cmd_valid_i) begin
      unique case (cmd_op_i)
        CMD_WR_EN:  latch_q <= 1'b1;
        CMD_WR_DIS: latch_q <= 1'b0;
        CMD_SR_WRITE:
          if (accept_o) begin
            lock_q  <= cmd_data_i[SR_LOCK];
            lvl_q   <= cmd_data_i[SR_LVL_LO +: LVL_W];
            latch_q <= 1'b0;
          end
        CMD_PAGE_PROG, CMD_SECT_ERASE, CMD_CHIP_ERASE:
          if (accept_o) latch_q <= 1'b0;
        default: ;
      endcase
    end
  end

  assign lock_o  = lock_q;
  assign lvl_o   = lvl_q;
  assign latch_o = latch_q;

  assert_latch_only_by_wren_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(latch_q) |-> $past(cmd_valid_i && cmd_op_i == CMD_WR_EN));

  assert_hw_lock_holds_sr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i == CMD_SR_WRITE && lock_q && !pin_high_i)
      |=> ($stable(lock_q) && $stable(lvl_q)));

  assert_reject_keeps_latch_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && !accept_o) |=> $stable(latch_q));
endmodule

// File: rtl/flash_wp_ctrl.sv
module flash_wp_ctrl
  import wp_pkg::*;
#(
  parameter int unsigned SECTOR_W    = 7,
  parameter int unsigned OFFSET_W    = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wp_n_i,
  input  logic                         cmd_valid_i,
  input  logic [2:0]                   cmd_op_i,
  input  logic [SECTOR_W+OFFSET_W-1:0] cmd_addr_i,
  input  logic [7:0]                   cmd_data_i,
  output logic                         rsp_valid_o,
  output logic                         rsp_accept_o,
  output logic [7:0]                   rsp_status_o,
  output logic                         hpm_o
);
  localparam int unsigned ADDR_W = SECTOR_W + OFFSET_W;

  logic             pin_high, sect_prot, accept, lock, latch;
  logic [LVL_W-1:0] lvl;
  logic             rsp_valid_q, rsp_accept_q, hpm_q;
  logic             unused_addr;
  wp_cmd_e          op;

  assign op          = wp_cmd_e'(cmd_op_i);
  assign unused_addr = ^cmd_addr_i[OFFSET_W-1:0];

  wp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(wp_n_i),
    .sync_o (pin_high)
  );

  wp_region #(.SECTOR_W(SECTOR_W)) u_region (
    .lvl_i   (lvl),
    .sector_i(cmd_addr_i[ADDR_W-1:OFFSET_W]),
    .prot_o  (sect_prot)
  );

  wp_core u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_valid_i(cmd_valid_i),
    .cmd_op_i   (op),
    .cmd_data_i (cmd_data_i),
    .sect_prot_i(sect_prot),
    .pin_high_i (pin_high),
    .accept_o   (accept),
    .lock_o     (lock),
    .lvl_o      (lvl),
    .latch_o    (latch)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q  <= 1'b0;
      rsp_accept_q <= 1'b0;
      hpm_q        <= 1'b0;
    end else begin
      rsp_valid_q  <= cmd_valid_i;
      rsp_accept_q <= cmd_valid_i & accept;
      hpm_q        <= lock & ~pin_high;
    end
  end

  always_comb begin
    rsp_status_o                      = '0;
    rsp_status_o[SR_LOCK]             = lock;
    rsp_status_o[SR_LVL_LO +: LVL_W]  = lvl;
    rsp_status_o[SR_LATCH]            = latch;
  end

  assign rsp_valid_o  = rsp_valid_q;
  assign rsp_accept_o = rsp_accept_q;
  assign hpm_o        = hpm_q;

  assert_rsp_one_cycle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i |=> rsp_valid_o);

  assert_chip_erase_fenced_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && op == CMD_CHIP_ERASE && lvl != '0) |=> !rsp_accept_o);

  assert_hpm_exit_by_pin_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hpm_q) |-> $past(pin_high));

  assert_reserved_rejected_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && (op == CMD_NOP || op == CMD_RSVD)) |=> !rsp_accept_o);
endmodule

// File: tb/flash_wp_ctrl_tb_top.sv
module flash_wp_ctrl_tb_top;
  localparam int SW = 7;
  localparam int OW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wp_n = 1'b1;
  logic          cmd_valid = 1'b0;
  logic [2:0]    cmd_op = '0;
  logic [SW+OW-1:0] cmd_addr = '0;
  logic [7:0]    cmd_data = '0;
  logic          rsp_valid, rsp_accept, hpm;
  logic [7:0]    rsp_status;

  int n_checks = 0;
  int n_fails  = 0;

  // bench model
  logic       m_lock = 0, m_latch = 0, m_pin = 1;
  logic [2:0] m_lvl = 0;

  logic [8:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  flash_wp_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wp_n_i(wp_n),
    .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op), .cmd_addr_i(cmd_addr),
    .cmd_data_i(cmd_data), .rsp_valid_o(rsp_valid), .rsp_accept_o(rsp_accept),
    .rsp_status_o(rsp_status), .hpm_o(hpm)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic in_fence(input logic [2:0] lvl, input int sector);
    if (lvl == 0) return 1'b0;
    if (lvl == 7) return 1'b1;
    return sector >= (128 - (1 << (lvl - 1)));
  endfunction

  function automatic logic [7:0] m_status();
    return {m_lock, 2'b00, m_lvl, m_latch, 1'b0};
  endfunction

  // driver: predict, enqueue, drive one cycle
  task automatic send(input logic [2:0] op, input int sector, input logic [7:0] data,
                      input string tag);
    logic acc;
    case (op)
      3'd1: begin acc = 1; m_latch = 1; end
      3'd2: begin acc = 1; m_latch = 0; end
      3'd3: begin
        acc = m_latch && !(m_lock && !m_pin);
        if (acc) begin m_lock = data[7]; m_lvl = data[4:2]; m_latch = 0; end
      end
      3'd4, 3'd5: begin
        acc = m_latch && !in_fence(m_lvl, sector);
        if (acc) m_latch = 0;
      end
      3'd6: begin
        acc = m_latch && (m_lvl == 0);
        if (acc) m_latch = 0;
      end
      default: acc = 0;
    endcase
    exp_q.push_back({acc, m_status()});
    tag_q.push_back(tag);
    @(posedge clk); #1;
    cmd_valid = 1; cmd_op = op; cmd_data = data;
    cmd_addr = {sector[SW-1:0], 16'h5a3c};
    @(posedge clk); #1;
    cmd_valid = 0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        check("R11 unexpected response", 1, 0);
      end else begin
        logic [8:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, {rsp_accept, rsp_status}, e);
      end
    end
  end

  task automatic set_pin(input logic v);
    wp_n = v;
    repeat (4) @(posedge clk);
    m_pin = v;
  endtask

  task automatic check_hpm(input string tag);
    @(negedge clk);
    check(tag, hpm, m_lock & ~m_pin);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fails++;
    $display("FAIL watchdog: actual hang expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 status", rsp_status, 8'h00);
    check("R1 hpm", hpm, 0);
    check("R1 rsp_valid", rsp_valid, 0);
    #1 rst_n = 1;
    repeat (2) @(posedge clk);

    send(3, 0, 8'h9c, "R3 sr write latch clear");
    send(1, 0, 0, "R2 wren");
    send(2, 0, 0, "R2 wrdi");
    send(4, 0, 0, "R10 prog without latch");
    send(1, 0, 0, "R2 wren");
    send(3, 0, 8'h6f, "R11 layout level3");
    // level 3: sectors 124..127 fenced
    send(1, 0, 0, "R2 wren");
    send(4, 124, 0, "R8 prog fenced lvl3");
    send(4, 123, 0, "R8 prog open lvl3");
    send(1, 0, 0, "R2 wren");
    send(5, 127, 0, "R8 erase fenced lvl3");
    send(5, 0, 0, "R8 erase open lvl3");
    send(1, 0, 0, "R2 wren");
    send(6, 0, 0, "R9 chip erase lvl3");
    send(7, 0, 8'hff, "R12 reserved op");
    send(0, 0, 8'hff, "R12 nop op");
    send(3, 0, 8'h1c, "R4 set level7");
    send(1, 0, 0, "R2 wren");
    send(4, 0, 0, "R8 prog lvl7");
    send(3, 0, 8'h04, "R4 set level1");
    send(1, 0, 0, "R2 wren");
    send(4, 127, 0, "R8 prog fenced lvl1");
    send(4, 126, 0, "R8 prog open lvl1");
    send(1, 0, 0, "R2 wren");
    send(3, 0, 8'h18, "R4 set level6");
    send(1, 0, 0, "R2 wren");
    send(5, 96, 0, "R8 erase fenced lvl6");
    send(5, 95, 0, "R8 erase open lvl6");
    send(1, 0, 0, "R2 wren");
    send(3, 0, 8'h00, "R4 clear level");
    send(1, 0, 0, "R2 wren");
    send(6, 0, 0, "R9 chip erase lvl0");
    send(2, 0, 0, "R10 wrdi after erase");

    // order A: lock bit set while pin already low
    set_pin(0);
    check_hpm("R4 pin low lock clear");
    send(1, 0, 0, "R2 wren");
    send(3, 0, 8'h84, "R4 set lock pin low");
    repeat (2) @(posedge clk);
    check_hpm("R6 hpm order A");
    send(1, 0, 0, "R2 wren");
    send(3, 0, 8'h00, "R6 sr write in hpm");
    send(2, 0, 0, "R2 wrdi in hpm");
    send(1, 0, 0, "R2 wren in hpm");
    repeat (2) @(posedge clk);
    check_hpm("R7 commands keep hpm");
    set_pin(1);
    check_hpm("R7 pin high exits");
    send(3, 0, 8'h80, "R5 lock set pin high");
    // order B: pin lowered after lock bit set
    set_pin(0);
    check_hpm("R6 hpm order B");
    send(1, 0, 0, "R2 wren");
    send(3, 0, 8'h00, "R6 sr write rejected B");
    // pin latency: two sync flops then registered output
    wp_n = 1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check("R7 hpm before third edge", hpm, 1);
    @(posedge clk); @(negedge clk);
    check("R7 hpm after third edge", hpm, 0);
    m_pin = 1;
    send(3, 0, 8'h00, "R5 unlock pin high");

    repeat (4) @(posedge clk);
    if (exp_q.size() != 0) check("R11 missing responses", exp_q.size(), 0);
    finish_run();
  end
endmodule